// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Counter

This block is an 8-bit up-counter with two compare registers and a wrap detector. The counter advances on a tick from a free-running prescaler. A three-bit field selects the tick rate: every 2, 8 or 64 clock cycles, or no tick at all. Three events set sticky status flags: the counter reaching compare value A, the counter reaching compare value B, and the counter wrapping from 0xFF to 0x00. Each flag drives an interrupt request when its enable bit is set.

A two-bit mode field chooses how the counter is cleared. It can be never cleared, cleared after a match on A, cleared after a match on B, or cleared by a rising edge on an asynchronous external input. Software reaches the control byte, the status flags, the counter and both compare values through a small register port with a read strobe and a write strobe. A build-time parameter produces a variant whose interrupt requests never assert.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: After reset the control byte reads 0x00, status 0x00, counter 0x00 and both compare registers 0xFF. The control byte is fully read/write at address 0. Its layout, from bit 7 down to bit 0, is compare-B enable, compare-A enable, wrap enable, clear mode[1:0], clock select[2:0].
- R2: Clock select 001, 010 and 011 advance the counter once every 2, 8 and 64 clock cycles respectively. Codes 000 and 100 to 111 hold the counter.
- R3: A compare flag (status bit 6 for A, bit 7 for B, status at address 1) is set one cycle after the counter (address 2) first becomes equal to the compare register (A at address 3, B at address 4).
- R4: The wrap flag (status bit 5) is set in the same cycle that a tick moves the counter from 0xFF to 0x00.
- R5: With clear mode 01 (or 10), the tick that follows a match on A (or B) loads 0 instead of incrementing. The counter then never exceeds the compare value.
- R6: With clear mode 11, a 0-to-1 transition of the external input clears the counter three clock edges after it is sampled. A held high level does not clear it again, and in other modes the input is ignored.
- R7: Writing 0 to a status bit clears that flag only if the flag was read as 1 beforehand. Writing 1, or writing 0 without that read, leaves the flag set.
- R8: When a hardware set of a flag coincides with a software clear of that flag, the flag stays 1.
- R9: Each interrupt request is high exactly while its flag and its enable bit are both 1.
- R10: With IRQ_ENABLE=0 all three interrupt requests stay 0 whatever the enables and flags hold.
- R11: A software write to the counter loads the written value at that clock edge. It takes priority over counting and over every clear source.
- R12: Addresses 5 to 7 and status bits 4 to 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms flag clearing) |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| ext_clr_in | input | 1 | Asynchronous external clear request |
| irq_cmpa | output | 1 | Compare-A interrupt request |
| irq_cmpb | output | 1 | Compare-B interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |

## Verification
The counter is run at each prescaler rate and under two stop codes over a 64-cycle window. The window length separates the three divide ratios exactly and shows that a reserved code does not count. Each clear mode is driven with compare values small enough that the counter would run past them if the wrong compare, or no compare, were used. The external input is given a single rising edge, a held level, and an edge in a non-external mode. The flag-clear protocol is tried with a write before any read, a write of ones, a proper read-then-write, and a clear that lands in the very cycle a match sets the flag. A second instance with interrupts disabled receives the same stimulus, which separates gating by the enable bits from suppression at build time.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

   typedef enum logic [2:0] {
      RA_CTRL = 3'd0,
      RA_STAT = 3'd1,
      RA_CNT  = 3'd2,
      RA_CMPA = 3'd3,
      RA_CMPB = 3'd4
   } reg_addr_e;

   typedef enum logic [1:0] {
      CLR_NONE = 2'd0,
      CLR_CMPA = 2'd1,
      CLR_CMPB = 2'd2,
      CLR_EXT  = 2'd3
   } clr_mode_e;

   typedef struct packed {
      logic      ie_b;
      logic      ie_a;
      logic      ie_o;
      clr_mode_e clr;
      logic [2:0] cks;
   } ctrl_t;

   // status flag vector index 0 = wrap, 1 = compare A, 2 = compare B
   localparam int FLAG_LSB = 5;
   localparam int NFLAGS   = 3;

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
   parameter int L1 = 1,
   parameter int L2 = 3,
   parameter int L3 = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cks,
   output logic       tick
);
   localparam int PW = L3;

   if (L1 < 1 || L1 >= L2 || L2 >= L3) begin : g_bad_taps
      $error("tmr8_prescale: taps must satisfy 1 <= L1 < L2 < L3");
   end

   logic [PW-1:0] pre_q;
   logic [2:0]    tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar g = 0; g < 3; g++) begin : g_tap
      localparam int LG = (g == 0) ? L1 : (g == 1) ? L2 : L3;
      assign tap[g] = &pre_q[LG-1:0];
   end

   always_comb begin
      case (cks)
         3'd1:    tick = tap[0];
         3'd2:    tick = tap[1];
         3'd3:    tick = tap[2];
         default: tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr8_edge_sync: at least two stages required");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
   import tmr8_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  clr_mode_e        mode,
   input  logic             ext_rise,
   input  logic             wr_cnt,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_b,
   output logic [CNT_W-1:0] cnt,
   output logic             set_a,
   output logic             set_b,
   output logic             set_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic eq_a, eq_b, eqa_q, eqb_q, match_clr, ext_clr;

   assign eq_a      = (cnt == cmp_a);
   assign eq_b      = (cnt == cmp_b);
   assign match_clr = ((mode == CLR_CMPA) && eq_a) || ((mode == CLR_CMPB) && eq_b);
   assign ext_clr   = (mode == CLR_EXT) && ext_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         eqa_q <= 1'b0;
         eqb_q <= 1'b0;
      end else begin
         eqa_q <= eq_a;
         eqb_q <= eq_b;
         if (wr_cnt)       cnt <= wdata;
         else if (ext_clr) cnt <= '0;
         else if (tick)    cnt <= match_clr ? '0 : cnt + 1'b1;
      end
   end

   assign set_a = eq_a & ~eqa_q;
   assign set_b = eq_b & ~eqb_q;
   assign set_o = tick & ~wr_cnt & ~ext_clr & (cnt == CNT_MAX);
endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wbit,
   output logic flag
);
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         arm_q <= 1'b0;
      end else if (hw_set) begin
         flag  <= 1'b1;
         arm_q <= 1'b0;
      end else if (wr_hit && !wbit && arm_q) begin
         flag  <= 1'b0;
         arm_q <= 1'b0;
      end else if (rd_hit && flag) begin
         arm_q <= 1'b1;
      end
   end
endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
   import tmr8_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter bit IRQ_ENABLE  = 1'b1,
   parameter int DIV_LO_LOG2 = 1,
   parameter int DIV_MD_LOG2 = 3,
   parameter int DIV_HI_LOG2 = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       reg_addr,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             ext_clr_in,
   output logic             irq_cmpa,
   output logic             irq_cmpb,
   output logic             irq_ovf
);
   localparam logic [CNT_W-1:0] CMP_RST = '1;

   if (CNT_W < 8) begin : g_bad_width
      $error("tmr8_dual_cmp: CNT_W must hold the 8-bit control byte");
   end

   ctrl_t              ctrl_q;
   logic [CNT_W-1:0]   cnt_q, cmpa_q, cmpb_q;
   logic               tick, ext_rise, cnt_wr, rd_stat, wr_stat;
   logic               set_a, set_b, set_o;
   logic [NFLAGS-1:0]  hw_set, flags, ie_vec;

   assign cnt_wr  = reg_wr && (reg_addr == RA_CNT);
   assign rd_stat = reg_rd && (reg_addr == RA_STAT);
   assign wr_stat = reg_wr && (reg_addr == RA_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmpa_q <= CMP_RST;
         cmpb_q <= CMP_RST;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_CTRL: ctrl_q <= ctrl_t'(reg_wdata[7:0]);
            RA_CMPA: cmpa_q <= reg_wdata;
            RA_CMPB: cmpb_q <= reg_wdata;
            default: ;
         endcase
      end
   end

   tmr8_prescale #(.L1(DIV_LO_LOG2), .L2(DIV_MD_LOG2), .L3(DIV_HI_LOG2)) u_pre (
      .clk(clk), .rst_n(rst_n), .cks(ctrl_q.cks), .tick(tick)
   );

   tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_clr_in), .rise(ext_rise)
   );

   tmr8_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(ctrl_q.clr),
      .ext_rise(ext_rise), .wr_cnt(cnt_wr), .wdata(reg_wdata),
      .cmp_a(cmpa_q), .cmp_b(cmpb_q), .cnt(cnt_q),
      .set_a(set_a), .set_b(set_b), .set_o(set_o)
   );

   assign hw_set = {set_b, set_a, set_o};

   for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
      tmr8_flag u_flag (
         .clk(clk), .rst_n(rst_n), .hw_set(hw_set[g]), .rd_hit(rd_stat),
         .wr_hit(wr_stat), .wbit(reg_wdata[FLAG_LSB+g]), .flag(flags[g])
      );
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: reg_rdata[7:0] = ctrl_q;
         RA_STAT: reg_rdata[FLAG_LSB +: NFLAGS] = flags;
         RA_CNT:  reg_rdata = cnt_q;
         RA_CMPA: reg_rdata = cmpa_q;
         RA_CMPB: reg_rdata = cmpb_q;
         default: ;
      endcase
   end

   assign ie_vec = {ctrl_q.ie_b, ctrl_q.ie_a, ctrl_q.ie_o};

   if (IRQ_ENABLE) begin : g_irq
      assign {irq_cmpb, irq_cmpa, irq_ovf} = flags & ie_vec;
   end else begin : g_no_irq
      assign {irq_cmpb, irq_cmpa, irq_ovf} = 3'b000;
   end
endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk #(
   parameter int CNT_W      = 8,
   parameter bit IRQ_ENABLE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cks,
   input logic [1:0]       clr,
   input logic             tick,
   input logic             ext_rise,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_a,
   input logic [2:0]       flags,
   input logic             set_a,
   input logic             ie_a,
   input logic             irq_a,
   input logic             irq_b,
   input logic             irq_o
);
   p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((cks == 3'd0 || cks > 3'd3) && !cnt_wr && !(clr == 2'd3 && ext_rise)) |=> $stable(cnt));

   p_cmp_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> ($past(cnt) == $past(cmp_a)));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> (cnt == '0));

   p_match_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr == 2'd1 && tick && cnt == cmp_a && !cnt_wr) |=> (cnt == '0));

   p_ext_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr == 2'd3 && ext_rise && !cnt_wr) |=> (cnt == '0));

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_a |=> flags[1]);

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> (ie_a && flags[1]));

   if (!IRQ_ENABLE) begin : g_off
      p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !(irq_a || irq_b || irq_o));
   end
endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(.CNT_W(CNT_W), .IRQ_ENABLE(IRQ_ENABLE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cks(ctrl_q.cks), .clr(ctrl_q.clr), .tick(tick),
   .ext_rise(ext_rise), .cnt_wr(cnt_wr), .cnt(cnt_q), .cmp_a(cmpa_q),
   .flags(flags), .set_a(set_a), .ie_a(ctrl_q.ie_a),
   .irq_a(irq_cmpa), .irq_b(irq_cmpb), .irq_o(irq_ovf)
);

// File: tb/tb_tmr8_dual_cmp.sv
module tb_tmr8_dual_cmp;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic       ext_clr_in = 1'b0;
   logic [7:0] rdata, rdata_n;
   logic       irq_a, irq_b, irq_o, nirq_a, nirq_b, nirq_o;

   int checks = 0;
   int errors = 0;
   string phase = "R1";

   always #4 clk = ~clk;

   tmr8_dual_cmp dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(rdata), .ext_clr_in(ext_clr_in),
      .irq_cmpa(irq_a), .irq_cmpb(irq_b), .irq_ovf(irq_o)
   );

   tmr8_dual_cmp #(.IRQ_ENABLE(1'b0)) dut_noirq (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .ext_clr_in(ext_clr_in),
      .irq_cmpa(nirq_a), .irq_cmpb(nirq_b), .irq_ovf(nirq_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_ctrl, m_cnt, m_ca, m_cb;
   bit   m_f [3];
   bit   m_arm [3];
   int   m_pre;
   bit   m_s1, m_s2, m_s3, m_ea, m_eb;

   function automatic bit tap(input int k);
      return (m_pre % (1 << k)) == ((1 << k) - 1);
   endfunction

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_ctrl;
         3'd1: return {m_f[2], m_f[1], m_f[0], 5'b0};
         3'd2: return m_cnt;
         3'd3: return m_ca;
         3'd4: return m_cb;
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 0; m_cnt = 0; m_ca = 8'hFF; m_cb = 8'hFF; m_pre = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ea = 0; m_eb = 0;
         for (int i = 0; i < 3; i++) begin m_f[i] = 0; m_arm[i] = 0; end
      end else begin
         bit tk, rise, eqa, eqb, wcnt, xclr, mclr, rds, wrs;
         bit st [3];
         case (m_ctrl[2:0])
            3'd1: tk = tap(1);
            3'd2: tk = tap(3);
            3'd3: tk = tap(6);
            default: tk = 0;
         endcase
         rise = m_s2 && !m_s3;
         eqa  = (m_cnt == m_ca);
         eqb  = (m_cnt == m_cb);
         wcnt = reg_wr && reg_addr == 3'd2;
         xclr = (m_ctrl[4:3] == 2'd3) && rise;
         mclr = (m_ctrl[4:3] == 2'd1 && eqa) || (m_ctrl[4:3] == 2'd2 && eqb);
         st[0] = !wcnt && !xclr && tk && m_cnt == 8'hFF;
         st[1] = eqa && !m_ea;
         st[2] = eqb && !m_eb;
         rds = reg_rd && reg_addr == 3'd1;
         wrs = reg_wr && reg_addr == 3'd1;
         for (int i = 0; i < 3; i++) begin
            if (st[i]) begin m_f[i] = 1; m_arm[i] = 0; end
            else if (wrs && !reg_wdata[5+i] && m_arm[i]) begin m_f[i] = 0; m_arm[i] = 0; end
            else if (rds && m_f[i]) m_arm[i] = 1;
         end
         if (wcnt)      m_cnt = reg_wdata;
         else if (xclr) m_cnt = 0;
         else if (tk)   m_cnt = mclr ? 8'h00 : m_cnt + 8'h01;
         m_ea = eqa; m_eb = eqb;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clr_in;
         m_pre = (m_pre + 1) % 64;
         if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata;
         if (reg_wr && reg_addr == 3'd3) m_ca = reg_wdata;
         if (reg_wr && reg_addr == 3'd4) m_cb = reg_wdata;
      end
   end

   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         check({phase, " model rdata"}, rdata, m_read(reg_addr));
         check({phase, " model irqs R9"}, {irq_b, irq_a, irq_o},
               {m_f[2] & m_ctrl[7], m_f[1] & m_ctrl[6], m_f[0] & m_ctrl[5]});
         check("R10 no-irq variant rdata", rdata_n, m_read(reg_addr));
         check("R10 no-irq variant irqs", {nirq_b, nirq_a, nirq_o}, 0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v, v0;
      int mx;
      bit seen;
      idle(3); rst_n = 1'b1;

      // R1 / R12 reset values and unused space
      phase = "R1";
      rd(3'd0, v); check("R1 ctrl reset", v, 8'h00);
      rd(3'd1, v); check("R1 status reset", v, 8'h00);
      rd(3'd2, v); check("R1 counter reset", v, 8'h00);
      rd(3'd3, v); check("R1 cmpA reset", v, 8'hFF);
      rd(3'd4, v); check("R1 cmpB reset", v, 8'hFF);
      for (int a = 5; a < 8; a++) begin rd(a[2:0], v); check("R12 unused address", v, 0); end
      wr(3'd0, 8'b1001_0000); rd(3'd0, v); check("R1 ctrl readback", v, 8'h90);
      wr(3'd0, 8'h00);

      // R2 tick rates and stop codes over a 64-cycle window
      phase = "R2";
      for (int c = 0; c < 5; c++) begin
         logic [2:0] code;
         int exp;
         code = (c < 3) ? c[2:0] + 3'd1 : (c == 3 ? 3'd0 : 3'd5);
         exp  = (c == 0) ? 32 : (c == 1) ? 8 : (c == 2) ? 1 : 0;
         wr(3'd2, 8'h00);
         wr(3'd0, {5'b0, code});
         rd(3'd2, v0); idle(62); rd(3'd2, v);
         check($sformatf("R2 delta for code %0d", code), 8'(v - v0), exp);
      end
      wr(3'd0, 8'h00);

      // R3 compare-B flag
      phase = "R3";
      wr(3'd4, 8'h10); wr(3'd2, 8'h08);
      rd(3'd1, v); check("R3 flag B clear before match", v[7], 0);
      wr(3'd0, 8'h01); idle(40); wr(3'd0, 8'h00);
      rd(3'd1, v); check("R3 flag B set after match", v[7], 1);
      check("R12 status low bits zero", v[4:0], 0);

      // R4 wrap flag
      phase = "R4";
      rd(3'd1, v); wr(3'd1, 8'h00);
      rd(3'd1, v); check("R4 flags cleared before wrap", v, 0);
      wr(3'd2, 8'hFD); wr(3'd0, 8'h01); idle(20); wr(3'd0, 8'h00);
      rd(3'd1, v); check("R4 wrap flag set", v[5], 1);
      rd(3'd2, v); check("R4 counter restarted low", int'(v < 8'h10), 1);

      // R5 compare clears
      phase = "R5";
      for (int m = 1; m <= 2; m++) begin
         logic [7:0] lim;
         lim = (m == 1) ? 8'h03 : 8'h05;
         wr((m == 1) ? 3'd3 : 3'd4, lim);
         wr(3'd2, 8'h00);
         wr(3'd0, {3'b000, m[1:0], 3'b001});
         @(negedge clk); reg_addr = 3'd2;
         mx = 0; seen = 0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk); #1;
            if (rdata > mx) mx = rdata;
            if (rdata == lim) seen = 1;
         end
         check($sformatf("R5 counter max mode %0d", m), mx, lim);
         check($sformatf("R5 reaches compare mode %0d", m), seen, 1);
      end
      wr(3'd0, 8'h00);

      // R6 external clear
      phase = "R6";
      wr(3'd0, 8'h18); wr(3'd2, 8'h55);
      @(negedge clk); ext_clr_in = 1'b1;
      idle(4); rd(3'd2, v); check("R6 rising edge clears", v, 0);
      wr(3'd2, 8'h55); idle(5); rd(3'd2, v); check("R6 held level ignored", v, 8'h55);
      @(negedge clk); ext_clr_in = 1'b0; idle(4);
      wr(3'd0, 8'h00);
      @(negedge clk); ext_clr_in = 1'b1; idle(5);
      rd(3'd2, v); check("R6 edge ignored in mode 00", v, 8'h55);
      @(negedge clk); ext_clr_in = 1'b0; idle(4);

      // R11 counter write wins over counting
      phase = "R11";
      wr(3'd0, 8'h01);
      @(negedge clk); reg_addr = 3'd2; reg_wdata = 8'h80; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0; #1;
      check("R11 written value visible", rdata, 8'h80);
      wr(3'd0, 8'h00);

      // R8 set coincides with clear
      phase = "R8";
      wr(3'd3, 8'h40); wr(3'd2, 8'h40); wr(3'd2, 8'h00);
      rd(3'd1, v); check("R8 flag A set", v[6], 1);
      @(negedge clk); reg_addr = 3'd2; reg_wdata = 8'h40; reg_wr = 1'b1;
      @(negedge clk); reg_addr = 3'd1; reg_wdata = 8'h00;
      @(negedge clk); reg_wr = 1'b0;
      rd(3'd1, v); check("R8 hardware set wins", v[6], 1);

      // R7 clear protocol
      phase = "R7";
      wr(3'd1, 8'h00);
      // preceding rd armed the flag; re-set it and clear without reading
      wr(3'd2, 8'h00); wr(3'd2, 8'h40); wr(3'd1, 8'h00);
      @(negedge clk); reg_addr = 3'd1; #1;
      check("R7 write 0 without read ignored", rdata[6], 1);
      rd(3'd1, v); wr(3'd1, 8'hE0);
      @(negedge clk); reg_addr = 3'd1; #1;
      check("R7 write 1 ignored", rdata[6], 1);
      wr(3'd1, 8'h00);
      @(negedge clk); reg_addr = 3'd1; #1;
      check("R7 read then write 0 clears", rdata[6], 0);

      // R9 / R10 interrupt gating
      phase = "R9";
      wr(3'd2, 8'h00); wr(3'd2, 8'h40);
      wr(3'd0, 8'h40); @(negedge clk); #1;
      check("R9 irq A with flag and enable", irq_a, 1);
      check("R9 irq B idle", irq_b, 0);
      check("R10 variant irq A suppressed", nirq_a, 0);
      wr(3'd0, 8'hA0); @(negedge clk); #1;
      check("R9 irq A off when disabled", irq_a, 0);
      check("R10 variant irqs suppressed", {nirq_a, nirq_b, nirq_o}, 0);

      idle(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule